// File: doc/BRIEF.md
# Demodulator Slot and Throughput Allocator

This block hands out demodulator slots to frontend channels while enforcing a shared decoder throughput budget. It also keeps a use count for each of the shared tuners. A client offers one request at a time on a valid/ready channel. An allocate request carries a channel number, a tuner index and a symbol rate. A release request carries only a channel number.

The allocator first derives a bits-per-symbol ceiling that fits a single demodulator's throughput cap. It then checks the summed ledger of throughput already granted against the total budget. Next it walks the slot table downward from a start index, which depends on whether the symbol rate is above half the master clock. It answers with a single-cycle response carrying:
- grant or busy,
- the chosen slot,
- the ceiling,
- a modulation mask.

Tuner enable and disable events come out as one-cycle side pulses.

The request channel has back-pressure. `req_ready` is high only while the allocator is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response and the tuner events carry no back-pressure: they are pulses that the consumer must take in the cycle they appear. Each request takes several cycles, including one cycle per slot probed.

Top module: `demod_slot_alloc`

## Requirements
- R1: `req_ready` is high only when the allocator is idle. Every accepted request, with `req_op`=0 for allocate and 1 for release, produces exactly one `rsp_valid` pulse of one cycle. No second request is accepted before that pulse.
- R2: The bits-per-symbol ceiling is the largest of 3 and 2 for which symbol_rate × bps ≤ 258,333,333 (1,550,000,000/6, integer). If neither value fits, the request is refused with busy (`rsp_busy`=1, `rsp_grant`=0). The products are computed without overflow for any 32-bit rate.
- R3: On grant, `rsp_mask` = (1 << (bps−1)) − 1, which gives 3 for bps 3 and 1 for bps 2.
- R4: A request is refused with busy when the sum of all channel ledger entries, taken before the request, is ≥ 720,000,000. Otherwise the budget does not limit the request, even if the new share pushes the sum past the budget.
- R5: The slot search starts at index 3 when the symbol rate is > 64,583,333 (half of 1,550,000,000/12, integer) and at index 7 otherwise. It walks downward and grants the first free slot, or answers busy when no slot at or below the start is free.
- R6: A grant marks the slot in use, records symbol_rate × bps as the channel's ledger entry, and records the slot on `rsp_demod` and as the channel's assignment.
- R7: A tuner-enable pulse (`tun_on_valid`, `tun_on_idx`) is emitted when a grant raises that tuner's use count from 0 to 1. Later grants on the same tuner emit nothing.
- R8: A tuner-disable pulse (`tun_off_valid`, `tun_off_idx`) is emitted when a release brings the count of the channel's tuner back to 0.
- R9: A release frees the channel's slot, clears its ledger entry and clears its assignment, then responds with grant=0 and busy=0. A release for a channel that holds no slot has no effect on slots, ledger or tuners.
- R10: An allocate request for a channel that already holds a slot first performs a full release of that slot. The release stands even if the new allocation is then refused.
- R11: After reset, `req_ready` is 1, no response or tuner pulse is present, all slots are free and all tuner counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Allocator idle, request taken on this edge |
| req_op | input | 1 | 0 allocate, 1 release |
| req_chan | input | 3 | Frontend channel |
| req_tuner | input | 2 | Tuner index (allocate only) |
| req_symrate | input | 32 | Symbol rate in symbols/s (allocate only) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_grant | output | 1 | Slot granted |
| rsp_busy | output | 1 | Allocation refused |
| rsp_demod | output | 3 | Granted slot |
| rsp_bps | output | 4 | Bits-per-symbol ceiling |
| rsp_mask | output | 8 | Modulation mask |
| tun_on_valid | output | 1 | Tuner enable pulse |
| tun_on_idx | output | 2 | Tuner to enable |
| tun_off_valid | output | 1 | Tuner disable pulse |
| tun_off_idx | output | 2 | Tuner to disable |

## Verification
The bench attacks the rate boundaries on either side of 86,111,111, 129,166,666 and 64,583,333:
- A comparison off by one at these values reports the wrong ceiling or mask, or starts the search at the wrong slot.
- A fill test with eight tiny-rate channels occupies every slot. A fast request made while only slots above index 3 are free must then be refused. A search that always began at the top would grant slot 6 or 7 instead.
- The budget test checks that a fourth large grant still passes and a fifth is refused. A design that tested the new total instead would refuse the fourth.

Random traffic with re-requests and releases compares tuner pulse counts against a model. This exposes a missed implicit release or a duplicated enable.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REL, ST_CHECK, ST_SEARCH, ST_GRANT, ST_DONE
  } alloc_state_t;

  localparam logic [7:0] NO_DEMOD = 8'hFF;
endpackage

// File: rtl/alloc_rate_eval.sv
module alloc_rate_eval #(
  parameter int SRW = 32,
  parameter int BPSW = 4,
  parameter int MASKW = 8,
  parameter int BPS_MAX = 3,
  parameter longint unsigned DEMOD_CAP = 64'd258_333_333,
  parameter longint unsigned HALF_MCLK = 64'd64_583_333
) (
  input  logic [SRW-1:0]   sym_rate,
  output logic [BPSW-1:0]  bps,
  output logic [MASKW-1:0] mask,
  output logic             fast,
  output logic [63:0]      share
);
  always_comb begin
    bps = '0;
    for (int b = 1; b <= BPS_MAX; b++) begin
      if (64'(sym_rate) * 64'(b) <= DEMOD_CAP) bps = BPSW'(b);
    end
    if (bps != '0) mask = MASKW'((64'd1 << (bps - 1'b1)) - 64'd1);
    else mask = '0;
    share = 64'(sym_rate) * 64'(bps);
    fast = 64'(sym_rate) > HALF_MCLK;
  end
endmodule

// File: rtl/alloc_ledger_sum.sv
module alloc_ledger_sum #(
  parameter int NUM_CH = 8
) (
  input  logic [63:0] entry [NUM_CH],
  output logic [63:0] total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < NUM_CH; i++) total = total + entry[i];
  end
endmodule

// File: rtl/alloc_tuner_refcnt.sv
module alloc_tuner_refcnt #(
  parameter int NUM_TUNER = 4,
  parameter int NUM_CH = 8,
  parameter int TW = $clog2(NUM_TUNER),
  parameter int CNTW = $clog2(NUM_CH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic [TW-1:0] inc_idx,
  input  logic          dec_en,
  input  logic [TW-1:0] dec_idx,
  output logic          on_valid,
  output logic [TW-1:0] on_idx,
  output logic          off_valid,
  output logic [TW-1:0] off_idx
);
  logic [CNTW-1:0] cnt [NUM_TUNER];
  logic [NUM_TUNER-1:0] idle_t;

  generate
    for (genvar t = 0; t < NUM_TUNER; t++) begin : g_zero
      assign idle_t[t] = (cnt[t] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TUNER; t++) cnt[t] <= '0;
      on_valid <= 1'b0;
      off_valid <= 1'b0;
      on_idx <= '0;
      off_idx <= '0;
    end else begin
      on_valid <= 1'b0;
      off_valid <= 1'b0;
      if (inc_en) begin
        cnt[inc_idx] <= cnt[inc_idx] + 1'b1;
        on_valid <= idle_t[inc_idx];
        on_idx <= inc_idx;
      end
      if (dec_en && !idle_t[dec_idx]) begin
        cnt[dec_idx] <= cnt[dec_idx] - 1'b1;
        off_valid <= (cnt[dec_idx] == CNTW'(1));
        off_idx <= dec_idx;
      end
    end
  end

  // R7
  on_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_valid |-> cnt[on_idx] == CNTW'(1));
  // R8
  off_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> cnt[off_idx] == '0);
endmodule

// File: rtl/demod_slot_alloc.sv
module demod_slot_alloc
  import alloc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_SLOT = 8,
  parameter int NUM_TUNER = 4,
  parameter int SRW = 32,
  parameter int BPSW = 4,
  parameter int MASKW = 8,
  parameter int FAST_START = 3,
  parameter longint unsigned TOTAL_BUDGET = 64'd720_000_000,
  parameter longint unsigned DEMOD_CAP = 64'd258_333_333,
  parameter longint unsigned MASTER_CLK = 64'd129_166_666,
  parameter int CHW = $clog2(NUM_CH),
  parameter int SLOTW = $clog2(NUM_SLOT),
  parameter int TW = $clog2(NUM_TUNER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [CHW-1:0]   req_chan,
  input  logic [TW-1:0]    req_tuner,
  input  logic [SRW-1:0]   req_symrate,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic             rsp_busy,
  output logic [SLOTW-1:0] rsp_demod,
  output logic [BPSW-1:0]  rsp_bps,
  output logic [MASKW-1:0] rsp_mask,
  output logic             tun_on_valid,
  output logic [TW-1:0]    tun_on_idx,
  output logic             tun_off_valid,
  output logic [TW-1:0]    tun_off_idx
);
  localparam longint unsigned HALF_MCLK = MASTER_CLK / 2;

  alloc_state_t state;
  logic [NUM_SLOT-1:0] in_use;
  logic [63:0] ledger [NUM_CH];
  logic [7:0] assigned [NUM_CH];
  logic [TW-1:0] chan_tun [NUM_CH];

  logic lat_op;
  logic [CHW-1:0] lat_ch;
  logic [TW-1:0] lat_tun;
  logic [SRW-1:0] lat_sr;
  logic [SLOTW-1:0] sidx;

  logic [BPSW-1:0] bps;
  logic [MASKW-1:0] mask;
  logic fast;
  logic [63:0] share;
  logic [63:0] used_total;

  alloc_rate_eval #(
    .SRW(SRW), .BPSW(BPSW), .MASKW(MASKW), .BPS_MAX(3),
    .DEMOD_CAP(DEMOD_CAP), .HALF_MCLK(HALF_MCLK)
  ) u_rate (
    .sym_rate(lat_sr), .bps(bps), .mask(mask), .fast(fast), .share(share)
  );

  alloc_ledger_sum #(.NUM_CH(NUM_CH)) u_sum (
    .entry(ledger), .total(used_total)
  );

  alloc_tuner_refcnt #(.NUM_TUNER(NUM_TUNER), .NUM_CH(NUM_CH), .TW(TW)) u_tun (
    .clk(clk), .rst_n(rst_n),
    .inc_en(state == ST_GRANT), .inc_idx(lat_tun),
    .dec_en(state == ST_REL), .dec_idx(chan_tun[lat_ch]),
    .on_valid(tun_on_valid), .on_idx(tun_on_idx),
    .off_valid(tun_off_valid), .off_idx(tun_off_idx)
  );

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      in_use <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ledger[i] <= '0;
        assigned[i] <= NO_DEMOD;
        chan_tun[i] <= '0;
      end
      lat_op <= 1'b0;
      lat_ch <= '0;
      lat_tun <= '0;
      lat_sr <= '0;
      sidx <= '0;
      rsp_grant <= 1'b0;
      rsp_busy <= 1'b0;
      rsp_demod <= '0;
      rsp_bps <= '0;
      rsp_mask <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          lat_op <= req_op;
          lat_ch <= req_chan;
          lat_tun <= req_tuner;
          lat_sr <= req_symrate;
          rsp_grant <= 1'b0;
          rsp_busy <= 1'b0;
          if (assigned[req_chan] != NO_DEMOD) state <= ST_REL;
          else if (req_op) state <= ST_DONE;
          else state <= ST_CHECK;
        end
        ST_REL: begin
          in_use[assigned[lat_ch][SLOTW-1:0]] <= 1'b0;
          ledger[lat_ch] <= '0;
          assigned[lat_ch] <= NO_DEMOD;
          state <= lat_op ? ST_DONE : ST_CHECK;
        end
        ST_CHECK: begin
          if (used_total >= TOTAL_BUDGET || bps < BPSW'(2)) begin
            rsp_busy <= 1'b1;
            state <= ST_DONE;
          end else begin
            sidx <= fast ? SLOTW'(FAST_START) : SLOTW'(NUM_SLOT - 1);
            state <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (!in_use[sidx]) state <= ST_GRANT;
          else if (sidx == '0) begin
            rsp_busy <= 1'b1;
            state <= ST_DONE;
          end else sidx <= sidx - 1'b1;
        end
        ST_GRANT: begin
          in_use[sidx] <= 1'b1;
          ledger[lat_ch] <= share;
          assigned[lat_ch] <= 8'(sidx);
          chan_tun[lat_ch] <= lat_tun;
          rsp_grant <= 1'b1;
          rsp_demod <= sidx;
          rsp_bps <= bps;
          rsp_mask <= mask;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  grant_bps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_grant |-> rsp_bps >= BPSW'(2));
  // R5
  fast_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_grant && fast |-> rsp_demod <= SLOTW'(FAST_START));
  // R6
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GRANT |-> !in_use[sidx]);
  // R9
  rel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_REL |-> assigned[lat_ch] != NO_DEMOD);
endmodule

// File: tb/sim_demod_slot_alloc.sv
module sim_demod_slot_alloc;
  localparam longint BUDGET = 720_000_000;
  localparam longint CAP = 258_333_333;
  localparam longint HALF = 64_583_333;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [2:0] req_chan = '0;
  logic [1:0] req_tuner = '0;
  logic [31:0] req_symrate = '0;
  logic req_ready, rsp_valid, rsp_grant, rsp_busy;
  logic [2:0] rsp_demod;
  logic [3:0] rsp_bps;
  logic [7:0] rsp_mask;
  logic tun_on_valid, tun_off_valid;
  logic [1:0] tun_on_idx, tun_off_idx;

  always #10 clk = ~clk;

  demod_slot_alloc u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chan(req_chan), .req_tuner(req_tuner),
    .req_symrate(req_symrate), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_busy(rsp_busy), .rsp_demod(rsp_demod), .rsp_bps(rsp_bps),
    .rsp_mask(rsp_mask), .tun_on_valid(tun_on_valid), .tun_on_idx(tun_on_idx),
    .tun_off_valid(tun_off_valid), .tun_off_idx(tun_off_idx)
  );

  int checks = 0, fails = 0;
  int cycles = 0;
  bit m_inuse [8];
  longint m_led [8];
  int m_asg [8];
  int m_tn [8];
  int m_cnt [4];
  int exp_on [4], exp_off [4], act_on [4], act_off [4];

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (tun_on_valid) act_on[tun_on_idx]++;
      if (tun_off_valid) act_off[tun_off_idx]++;
    end
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bps_of(longint sr);
    if (sr * 3 <= CAP) return 3;
    if (sr * 2 <= CAP) return 2;
    return 1;
  endfunction

  task automatic model_release(int ch);
    if (m_asg[ch] >= 0) begin
      m_inuse[m_asg[ch]] = 0;
      m_led[ch] = 0;
      m_asg[ch] = -1;
      m_cnt[m_tn[ch]]--;
      if (m_cnt[m_tn[ch]] == 0) exp_off[m_tn[ch]]++;
    end
  endtask

  task automatic model_alloc(int ch, int tn, longint sr,
                             output bit g, output int d, output int b);
    longint sum = 0;
    model_release(ch);
    for (int i = 0; i < 8; i++) sum += m_led[i];
    b = bps_of(sr);
    g = 0; d = -1;
    if (sum < BUDGET && b >= 2) begin
      for (int i = (sr > HALF) ? 3 : 7; i >= 0; i--)
        if (!m_inuse[i]) begin d = i; break; end
    end
    if (d >= 0) begin
      g = 1;
      m_inuse[d] = 1;
      m_led[ch] = sr * b;
      m_asg[ch] = d;
      m_tn[ch] = tn;
      if (m_cnt[tn] == 0) exp_on[tn]++;
      m_cnt[tn]++;
    end
  endtask

  task automatic issue(bit op, int ch, int tn, longint sr);
    int w = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_chan = 3'(ch);
    req_tuner = 2'(tn); req_symrate = 32'(sr);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1", "ready after accept", req_ready, 0);
    while (!rsp_valid && w < 40) begin @(negedge clk); w++; end
  endtask

  task automatic do_req(bit op, int ch, int tn, longint sr,
                        output bit g, output int d, output int b);
    issue(op, ch, tn, sr);
    if (op) begin
      model_release(ch);
      g = 0; d = -1; b = 0;
      chk(rsp_valid && !rsp_grant && !rsp_busy, "R9", "release response",
          {rsp_valid, rsp_grant, rsp_busy}, 3'b100);
    end else begin
      model_alloc(ch, tn, sr, g, d, b);
      chk(rsp_valid && rsp_grant == g && rsp_busy == !g, "R4", "grant/busy",
          {rsp_valid, rsp_grant, rsp_busy}, {1'b1, g, !g});
      if (g) begin
        chk(rsp_demod == 3'(d), "R5", "slot", rsp_demod, d);
        chk(rsp_bps == 4'(b), "R2", "bps", rsp_bps, b);
        chk(rsp_mask == 8'((1 << (b - 1)) - 1), "R3", "mask", rsp_mask, (1 << (b - 1)) - 1);
      end
    end
    @(negedge clk);
    chk(!rsp_valid, "R1", "pulse width", rsp_valid, 0);
    for (int t = 0; t < 4; t++) begin
      chk(act_on[t] == exp_on[t], "R7", "enable count", act_on[t], exp_on[t]);
      chk(act_off[t] == exp_off[t], "R8", "disable count", act_off[t], exp_off[t]);
    end
  endtask

  task automatic clear_all();
    bit g; int d, b;
    for (int c = 0; c < 8; c++) do_req(1, c, 0, 0, g, d, b);
  endtask

  initial begin
    bit g; int d, b;
    longint edges [6] = '{64_583_333, 64_583_334, 86_111_111, 86_111_112,
                         129_166_666, 129_166_667};
    for (int i = 0; i < 8; i++) begin m_inuse[i] = 0; m_led[i] = 0; m_asg[i] = -1; m_tn[i] = 0; end
    for (int t = 0; t < 4; t++) begin m_cnt[t] = 0; exp_on[t] = 0; exp_off[t] = 0; act_on[t] = 0; act_off[t] = 0; end
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready, "R11", "ready", req_ready, 1);
    chk(!rsp_valid && !tun_on_valid && !tun_off_valid, "R11", "no pulses",
        {rsp_valid, tun_on_valid, tun_off_valid}, 0);

    // R2 R3 R5 rate boundaries, one at a time on a clean table
    foreach (edges[k]) begin
      do_req(0, 0, 1, edges[k], g, d, b);
      case (k)
        0: chk(g && d == 7 && b == 3, "R5", "half-clock edge low", d, 7);
        1: chk(g && d == 3 && b == 3, "R5", "half-clock edge high", d, 3);
        2: chk(g && b == 3, "R2", "bps3 edge", b, 3);
        3: chk(g && b == 2 && rsp_mask == 8'd1, "R3", "bps2 mask", rsp_mask, 1);
        4: chk(g && b == 2, "R2", "bps2 edge", b, 2);
        default: chk(!g && rsp_busy, "R2", "rate too high", rsp_busy, 1);
      endcase
      do_req(1, 0, 0, 0, g, d, b);
    end

    // R9 release of an idle channel has no effect
    do_req(1, 5, 0, 0, g, d, b);
    do_req(0, 5, 2, 1_000_000, g, d, b);
    chk(g && d == 7, "R9", "table untouched after idle release", d, 7);
    clear_all();

    // R4 budget: 195M shares, fourth passes (585M<720M), fifth refused
    for (int c = 0; c < 5; c++) begin
      do_req(0, c, 0, 65_000_000, g, d, b);
      chk(g == (c < 4), "R4", "budget gate", g, c < 4);
    end
    clear_all();

    // R5 R6 R10 fill every slot with tiny rates, then fast search exhaustion
    for (int c = 0; c < 8; c++) begin
      do_req(0, c, c % 4, 1_000_000, g, d, b);
      chk(d == 7 - c, "R6", "fill order", d, 7 - c);
    end
    do_req(1, 0, 0, 0, g, d, b);
    do_req(0, 1, 3, 70_000_000, g, d, b);
    chk(!g, "R5", "fast search ignores slots above start", g, 0);
    do_req(0, 1, 3, 2_000_000, g, d, b);
    chk(g && d == 7, "R10", "implicit release left slot free", d, 7);
    clear_all();

    // R10 re-request on the same channel keeps one tuner reference
    do_req(0, 2, 1, 3_000_000, g, d, b);
    do_req(0, 2, 1, 4_000_000, g, d, b);
    chk(g && d == 7, "R10", "re-request reuses freed slot", d, 7);
    clear_all();

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int ch = int'($urandom % 8);
      int tn = int'($urandom % 4);
      longint sr;
      case ($urandom % 5)
        0: sr = 1_000_000 + longint'($urandom % 63_000_000);
        1: sr = 64_583_334 + longint'($urandom % 21_000_000);
        2: sr = 86_111_112 + longint'($urandom % 43_000_000);
        3: sr = 129_166_667 + longint'($urandom % 100_000_000);
        default: sr = edges[$urandom % 6];
      endcase
      do_req(($urandom % 4) == 0, ch, tn, sr, g, d, b);
    end
    finish_run();
  end
endmodule